// File: doc/BRIEF.md
# Filtered Quadrature Position Counter

This block turns the two phase outputs of an incremental rotary or linear encoder into a 16-bit unsigned position that a host polls. The two encoder phases and an optional index line arrive unsynchronized. Each of the three lines first passes through a two-flop synchronizer. It then goes through a glitch filter, which the host enables per line. The filter samples on a tick from a shared divider of the system clock. A level reaches the decoder only after three consecutive ticks have seen it.

The decoder works at four-times resolution, so each accepted edge on either phase moves the count by one. The order of the phase pair, written as {A,B}, is 00, 01, 11, 10. Moving forward through that order counts up and moving backward counts down. Counting up from the host-supplied limit wraps to zero, and counting down from zero reloads the limit. If both phases change in the same cycle, the move is impossible to decode. The count is then left alone and a sticky error flag is raised.

With the decoder switched off, the host may preset the count or clear it before switching it back on. The filtered index line is brought out for the surrounding logic.

Top module: `qpos_counter`

## Requirements
- R1: With filtering off, a level change on a phase input shows up in `position` on the fourth rising clock edge after it is applied, and not earlier.
- R2: While `count_en` is 1, a move of {A,B} one step forward in the order 00→01→11→10→00 raises `position` by one. A sample with no change leaves it unchanged.
- R3: A move of one step backward in that order (00→10→11→01→00) lowers `position` by one.
- R4: Counting up while `position` is at or above `max_count` gives 0 on the next count.
- R5: Counting down while `position` is 0 gives the current `max_count`.
- R6: A change of both filtered phases in the same cycle (00↔11 or 01↔10) leaves `position` unchanged and sets `count_err`.
- R7: `count_err` stays set until a cycle with `clr_err` high. A new error in the same cycle as `clr_err` wins, and the flag stays set.
- R8: With its bit of `filt_en` set (bit 0 = A, bit 1 = B, bit 2 = index), a line ignores a pulse of 4 clocks or shorter. It passes a level held for 6 or more clocks after the synchronizer. With the bit clear, even a one-clock pulse gets through. Bit 2 is observed at `idx_clean`.
- R9: While `count_en` is 0, phase moves do not change `position`. Moves made while off cause no count when counting is re-enabled.
- R10: `clr_pos` and `load_en` act only while `count_en` is 0. `clr_pos` takes priority over `load_en`, and `load_en` writes `load_val`. While `count_en` is 1, both are ignored.
- R11: After reset, `position` is 0, `count_err` is 0 and `idx_clean` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| enc_a | input | 1 | Raw phase A, asynchronous |
| enc_b | input | 1 | Raw phase B, asynchronous |
| enc_idx | input | 1 | Raw index line, asynchronous |
| filt_en | input | 3 | Per-line glitch filter enable (0 = A, 1 = B, 2 = index) |
| count_en | input | 1 | Decoder enable; 0 stops counting and allows preset |
| max_count | input | 16 | Wrap limit of the count |
| clr_pos | input | 1 | Clear count to 0 while disabled |
| load_en | input | 1 | Load `load_val` while disabled |
| load_val | input | 16 | Preset value |
| clr_err | input | 1 | Clear the sticky error flag |
| position | output | 16 | Current count |
| count_err | output | 1 | Sticky flag for impossible double moves |
| idx_clean | output | 1 | Synchronized, optionally filtered index |

## Verification
Raising the error flag and clearing it are two separate functions that can meet in one cycle. The bench provokes this by flipping both phases at once and then holding `clr_err` exactly in the cycle before the fourth edge, when the decoder sees the double move. It judges the result by requiring `count_err` to read 1 after that edge and 0 only after a later lone clear. A second meeting point is a count arriving exactly at the wrap limit. The bench walks a small limit in both directions and compares each step with an arithmetic model of the wrap.

// File: rtl/qpos_pkg.sv
package qpos_pkg;

  // Decoded result of comparing two successive filtered phase samples.
  typedef enum logic [1:0] {
    MV_HOLD = 2'd0,
    MV_UP   = 2'd1,
    MV_DOWN = 2'd2,
    MV_BAD  = 2'd3
  } move_e;

  // Position of a {A,B} pair along the forward sequence 00,01,11,10.
  function automatic logic [1:0] phase_rank(input logic [1:0] ab);
    case (ab)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      2'b11:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  function automatic move_e classify_move(input logic [1:0] prev_ab,
                                          input logic [1:0] cur_ab);
    logic [1:0] delta;
    delta = phase_rank(cur_ab) - phase_rank(prev_ab);
    case (delta)
      2'd0:    return MV_HOLD;
      2'd1:    return MV_UP;
      2'd3:    return MV_DOWN;
      default: return MV_BAD;
    endcase
  endfunction

endpackage

// File: rtl/qpos_input_filter.sv
module qpos_input_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD        = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic filt_on,
  input  logic tick,
  output logic clean
);

  localparam int CNT_W = (HOLD > 1) ? $clog2(HOLD + 1) : 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   synced;
  logic [CNT_W-1:0]       agree_cnt;
  logic                   accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
  end

  assign synced = sync_q[SYNC_STAGES-1];

  // A new level is taken on the HOLD-th consecutive tick that sees it.
  assign accept = filt_on && tick && (synced != clean) &&
                  (agree_cnt == CNT_W'(HOLD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clean     <= 1'b0;
      agree_cnt <= '0;
    end else if (!filt_on) begin
      clean     <= synced;
      agree_cnt <= '0;
    end else if (tick) begin
      if (synced == clean) begin
        agree_cnt <= '0;
      end else if (accept) begin
        clean     <= synced;
        agree_cnt <= '0;
      end else begin
        agree_cnt <= agree_cnt + CNT_W'(1);
      end
    end
  end

  // R8: a filtered line never moves between sample ticks
  a_r8_moves_on_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_on && !tick) |=> $stable(clean));

  // R8: a tick that agrees with the output never changes it
  a_r8_agree_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_on && tick && (synced == clean)) |=> $stable(clean));

endmodule

// File: rtl/qpos_dir_decode.sv
module qpos_dir_decode
  import qpos_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic [1:0] ab,
  output logic       step_up,
  output logic       step_down,
  output logic       step_bad
);

  logic [1:0] prev_ab;
  move_e      mv;

  // The previous sample follows the inputs even while disabled, so that
  // re-enabling never sees a stale pair.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_ab <= 2'b00;
    else        prev_ab <= ab;
  end

  assign mv        = classify_move(prev_ab, ab);
  assign step_up   = enable && (mv == MV_UP);
  assign step_down = enable && (mv == MV_DOWN);
  assign step_bad  = enable && (mv == MV_BAD);

  // R2 / R3: a counted move changes exactly one phase
  a_r2_single_phase_move: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up || step_down) |-> ($countones(prev_ab ^ ab) == 1));

  // R6: an error event is a change of both phases
  a_r6_bad_is_double: assert property (@(posedge clk) disable iff (!rst_n)
    step_bad |-> ((prev_ab ^ ab) == 2'b11));

endmodule

// File: rtl/qpos_pos_counter.sv
module qpos_pos_counter #(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             step_up,
  input  logic             step_down,
  input  logic             step_bad,
  input  logic [POS_W-1:0] max_count,
  input  logic             clr_pos,
  input  logic             load_en,
  input  logic [POS_W-1:0] load_val,
  input  logic             clr_err,
  output logic [POS_W-1:0] position,
  output logic             count_err
);

  function automatic logic [POS_W-1:0] wrap_inc(input logic [POS_W-1:0] p,
                                                input logic [POS_W-1:0] lim);
    return (p >= lim) ? '0 : p + POS_W'(1);
  endfunction

  function automatic logic [POS_W-1:0] wrap_dec(input logic [POS_W-1:0] p,
                                                input logic [POS_W-1:0] lim);
    return (p == '0) ? lim : p - POS_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      position <= '0;
    end else if (!enable) begin
      if (clr_pos)      position <= '0;
      else if (load_en) position <= load_val;
    end else if (step_up) begin
      position <= wrap_inc(position, max_count);
    end else if (step_down) begin
      position <= wrap_dec(position, max_count);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_err <= 1'b0;
    else if (step_bad) count_err <= 1'b1;
    else if (clr_err)  count_err <= 1'b0;
  end

  // R4: forward count at the limit lands on zero
  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && (position == max_count)) |=> (position == '0));

  // R5: backward count from zero lands on the limit
  a_r5_under_to_max: assert property (@(posedge clk) disable iff (!rst_n)
    (step_down && (position == '0)) |=> (position == $past(max_count)));

  // R6: an impossible move leaves the count alone
  a_r6_bad_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    step_bad |=> $stable(position));

  // R7: an error raised together with a clear still sets the flag
  a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    step_bad |=> count_err);

  // R10: host preset and clear are ignored while counting is on
  a_r10_ignore_host_when_on: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !step_up && !step_down) |=> $stable(position));

  // R10: clear has priority over load while off
  a_r10_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && clr_pos) |=> (position == '0));

endmodule

// File: rtl/qpos_counter.sv
module qpos_counter #(
  parameter int POS_W       = 16,
  parameter int FILT_DIV    = 2,
  parameter int FILT_HOLD   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             enc_idx,
  input  logic [2:0]       filt_en,
  input  logic             count_en,
  input  logic [POS_W-1:0] max_count,
  input  logic             clr_pos,
  input  logic             load_en,
  input  logic [POS_W-1:0] load_val,
  input  logic             clr_err,
  output logic [POS_W-1:0] position,
  output logic             count_err,
  output logic             idx_clean
);

  localparam int N_LINES = 3;
  localparam int DIV_W   = (FILT_DIV > 1) ? $clog2(FILT_DIV) : 1;

  logic [DIV_W-1:0]   div_cnt;
  logic               filt_tick;
  logic [N_LINES-1:0] raw_in;
  logic [N_LINES-1:0] clean;
  logic               step_up, step_down, step_bad;

  // Shared sample tick for all filters: one pulse every FILT_DIV clocks.
  assign filt_tick = (div_cnt == DIV_W'(FILT_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         div_cnt <= '0;
    else if (filt_tick) div_cnt <= '0;
    else                div_cnt <= div_cnt + DIV_W'(1);
  end

  assign raw_in = {enc_idx, enc_b, enc_a};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    qpos_input_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .HOLD       (FILT_HOLD)
    ) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw    (raw_in[g]),
      .filt_on(filt_en[g]),
      .tick   (filt_tick),
      .clean  (clean[g])
    );
  end

  assign idx_clean = clean[2];

  qpos_dir_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (count_en),
    .ab       ({clean[0], clean[1]}),
    .step_up  (step_up),
    .step_down(step_down),
    .step_bad (step_bad)
  );

  qpos_pos_counter #(.POS_W(POS_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (count_en),
    .step_up  (step_up),
    .step_down(step_down),
    .step_bad (step_bad),
    .max_count(max_count),
    .clr_pos  (clr_pos),
    .load_en  (load_en),
    .load_val (load_val),
    .clr_err  (clr_err),
    .position (position),
    .count_err(count_err)
  );

  // R9: with counting off, no decode event reaches the counter
  a_r9_silent_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !clr_pos && !load_en) |=> $stable(position));

endmodule

// File: tb/tb_qpos_counter.sv
module tb_qpos_counter;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
  logic [2:0]  filt_en = 3'b000;
  logic        count_en = 1'b0;
  logic [15:0] max_count = 16'hFFFF;
  logic        clr_pos = 1'b0, load_en = 1'b0, clr_err = 1'b0;
  logic [15:0] load_val = 16'h0000;
  logic [15:0] position;
  logic        count_err;
  logic        idx_clean;

  int checks = 0;
  int fails  = 0;
  logic [1:0] cur_ab = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  qpos_counter dut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .filt_en(filt_en), .count_en(count_en), .max_count(max_count),
    .clr_pos(clr_pos), .load_en(load_en), .load_val(load_val), .clr_err(clr_err),
    .position(position), .count_err(count_err), .idx_clean(idx_clean)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Advance n rising edges, ending on the following falling edge.
  task automatic cyc(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // Forward index of {A,B}: {A, A^B} read as binary.
  function automatic logic [1:0] rank(input logic [1:0] ab);
    return {ab[1], ab[1] ^ ab[0]};
  endfunction

  function automatic logic [1:0] unrank(input logic [1:0] r);
    return {r[1], r[1] ^ r[0]};
  endfunction

  function automatic logic [15:0] model_up(input logic [15:0] p, input logic [15:0] m);
    return (p >= m) ? 16'd0 : 16'(p + 16'd1);
  endfunction

  function automatic logic [15:0] model_dn(input logic [15:0] p, input logic [15:0] m);
    return (p == 16'd0) ? m : 16'(p - 16'd1);
  endfunction

  task automatic set_ab(input logic [1:0] ab);
    enc_a  = ab[1];
    enc_b  = ab[0];
    cur_ab = ab;
  endtask

  task automatic pulse_clr_err();
    clr_err = 1'b1; cyc(1); clr_err = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] exp_pos;
    logic        seen;

    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R11: reset state
    chk("R11 position", position, 0);
    chk("R11 count_err", count_err, 0);
    chk("R11 idx_clean", idx_clean, 0);

    count_en = 1'b1;
    cyc(4);

    // R1: latency of four edges with filter off; 00 -> 01 is forward
    set_ab(2'b01);
    cyc(3);
    chk("R1 not yet", position, 0);
    cyc(1);
    chk("R1 arrived", position, 1);

    // R2 / R3 / R6: every pair of successive samples
    for (int s = 0; s < 4; s++) begin
      for (int n = 0; n < 4; n++) begin
        logic [1:0] d;
        logic [15:0] base;
        set_ab(2'(s));
        cyc(8);
        pulse_clr_err();
        cyc(1);
        base = position;
        set_ab(2'(n));
        cyc(8);
        d = rank(2'(n)) - rank(2'(s));
        if (d == 2'd1) begin
          chk("R2 forward step", position, model_up(base, 16'hFFFF));
          chk("R2 no error", count_err, 0);
        end else if (d == 2'd3) begin
          chk("R3 backward step", position, model_dn(base, 16'hFFFF));
          chk("R3 no error", count_err, 0);
        end else if (d == 2'd2) begin
          chk("R6 count held", position, base);
          chk("R6 error set", count_err, 1);
        end else begin
          chk("R2 idle sample", position, base);
        end
      end
    end

    // R7: error and clear in the same cycle; set wins
    set_ab(2'b00);
    cyc(8);
    pulse_clr_err();
    exp_pos = position;
    set_ab(2'b11);
    cyc(3);
    chk("R7 before event", count_err, 0);
    clr_err = 1'b1;
    cyc(1);
    clr_err = 1'b0;
    chk("R7 set beats clear", count_err, 1);
    cyc(5);
    chk("R7 sticky", count_err, 1);
    chk("R6 count unchanged", position, exp_pos);
    pulse_clr_err();
    chk("R7 lone clear", count_err, 0);

    // R4 / R5: wrap sweep on a small limit
    count_en = 1'b0;
    max_count = 16'd5;
    clr_pos = 1'b1; cyc(1); clr_pos = 1'b0;
    count_en = 1'b1;
    cyc(2);
    exp_pos = 16'd0;
    for (int i = 0; i < 14; i++) begin
      set_ab(unrank(rank(cur_ab) + 2'd1));
      cyc(6);
      exp_pos = model_up(exp_pos, max_count);
      chk("R4 up sweep", position, exp_pos);
    end
    for (int i = 0; i < 14; i++) begin
      set_ab(unrank(rank(cur_ab) - 2'd1));
      cyc(6);
      exp_pos = model_dn(exp_pos, max_count);
      chk("R5 down sweep", position, exp_pos);
    end

    // R9: moves while off are not counted, nor on re-enable
    count_en = 1'b0;
    exp_pos = position;
    for (int i = 0; i < 3; i++) begin
      set_ab(unrank(rank(cur_ab) + 2'd1));
      cyc(6);
    end
    chk("R9 off no count", position, exp_pos);
    count_en = 1'b1;
    cyc(6);
    chk("R9 no jump on enable", position, exp_pos);
    set_ab(unrank(rank(cur_ab) + 2'd1));
    cyc(6);
    chk("R9 counts again", position, model_up(exp_pos, max_count));

    // R10: host preset only while off, clear before load
    max_count = 16'hFFFF;
    exp_pos = position;
    load_val = 16'h1234; load_en = 1'b1; cyc(1); load_en = 1'b0;
    chk("R10 load ignored when on", position, exp_pos);
    clr_pos = 1'b1; cyc(1); clr_pos = 1'b0;
    chk("R10 clear ignored when on", position, exp_pos);
    count_en = 1'b0;
    load_en = 1'b1; cyc(1); load_en = 1'b0;
    chk("R10 load when off", position, 16'h1234);
    load_en = 1'b1; clr_pos = 1'b1; cyc(1); load_en = 1'b0; clr_pos = 1'b0;
    chk("R10 clear beats load", position, 0);
    count_en = 1'b1;
    cyc(4);

    // R8: filtered phases drop a 3-clock double glitch
    filt_en = 3'b011;
    cyc(20);
    pulse_clr_err();
    exp_pos = position;
    enc_a = ~cur_ab[1]; enc_b = ~cur_ab[0];
    cyc(3);
    enc_a = cur_ab[1]; enc_b = cur_ab[0];
    cyc(20);
    chk("R8 glitch dropped err", count_err, 0);
    chk("R8 glitch dropped pos", position, exp_pos);
    // same glitch unfiltered is seen as a double move
    filt_en = 3'b000;
    cyc(4);
    enc_a = ~cur_ab[1]; enc_b = ~cur_ab[0];
    cyc(3);
    enc_a = cur_ab[1]; enc_b = cur_ab[0];
    cyc(12);
    chk("R8 unfiltered glitch seen", count_err, 1);
    pulse_clr_err();
    // a held move passes the filter
    filt_en = 3'b011;
    cyc(4);
    exp_pos = position;
    set_ab(unrank(rank(cur_ab) + 2'd1));
    cyc(20);
    chk("R8 held move passes", position, model_up(exp_pos, 16'hFFFF));

    // R8: index filter
    filt_en = 3'b100;
    enc_idx = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (i == 3) enc_idx = 1'b0;
      cyc(1);
      if (idx_clean) seen = 1'b1;
    end
    chk("R8 index glitch dropped", seen, 0);
    enc_idx = 1'b1;
    cyc(20);
    chk("R8 index held passes", idx_clean, 1);
    enc_idx = 1'b0;
    cyc(20);
    filt_en = 3'b000;
    seen = 1'b0;
    enc_idx = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (i == 1) enc_idx = 1'b0;
      cyc(1);
      if (idx_clean) seen = 1'b1;
    end
    chk("R8 index unfiltered pulse", seen, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule